// File: doc/BRIEF.md
# Saturating BER Bit Counter

This block tallies the data bits received by a bit-error-rate tester. Each cycle that the recovered bit clock enable is high, the count advances by one. It counts only while the pattern detector reports lock. When lock drops, the count freezes. Counting picks up again from the frozen value once lock returns. Software clears the count by taking a control level from low to high. The block detects that rising edge itself, so software never writes the count directly.

The count does not wrap. Once it reaches all-ones it stays there, and a sticky overflow flag goes high at the same time. Only a clear or a reset brings the flag low again.

Software reads the count a byte at a time through a read-only register port. The byte window starts at address 0xE3. Reading the lowest byte also takes a snapshot of the whole count. The higher bytes are then served from that snapshot, so a multi-byte read returns one consistent value even while counting goes on.

Top module: `berBitTally`

## Requirements
- R1: After reset the count is zero, the overflow flag is low and the read data output is zero.
- R2: On each rising clock edge where `bitEn` and `syncOk` are both high and the count is not all-ones, the count increases by exactly one.
- R3: While `syncOk` is low, `bitEn` has no effect and the count holds its value. Counting resumes from that value when `syncOk` returns high.
- R4: A clear happens on the edge where `clrCtl` is sampled high after being sampled low on the previous edge. That edge sets the count to zero, and the clear wins over an increment in the same cycle. Holding `clrCtl` high, or taking it low, has no effect on the count.
- R5: Once the count is all-ones (2^CNT_W - 1), further enabled cycles leave it at all-ones.
- R6: `ovfFlag` goes high on the same edge that the count becomes all-ones. It then stays high until a clear or a reset.
- R7: A read (`rdEn` high at an edge) of address 0xE3 returns count bits 7:0 on `rdData` one cycle later and snapshots the full count. A read of 0xE3+k, for k from 1 to CNT_W/8-1, returns bits 8k+7:8k of the most recent snapshot.
- R8: A read of any address outside 0xE3 to 0xE3+CNT_W/8-1 returns zero. While `rdEn` is low, `rdData` keeps its last value.
- R9: A clear also forces `ovfFlag` low, even if an increment occurs in the same cycle.
- R10: Counting after a snapshot does not change what the higher byte addresses return until 0xE3 is read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle enable per received data bit |
| syncOk | input | 1 | Pattern lock indication from the detector |
| clrCtl | input | 1 | Clear control level; a low-to-high change clears the count |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 8 | Register byte address |
| rdData | output | 8 | Read data, valid the cycle after a read |
| ovfFlag | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that `syncOk`, `bitEn`, `clrCtl` and the read inputs are synchronous to `clk` and stable around its rising edge. They also assume that reset is held low for at least one edge before any property is evaluated. The bench changes every input only on the falling edge and holds reset across several edges at start-up. It runs a 32-bit copy and a 16-bit copy of the block in parallel with the same stimulus, so that saturation and the upper end of the address window are reached within the run.

// File: rtl/berTallyPkg.sv
package berTallyPkg;

  // Width of the byte selector carried from control to datapath.
  localparam int SEL_W = 4;

  // Strobes issued by the control half each cycle.
  typedef struct packed {
    logic             clear;    // single-cycle clear from control edge
    logic             step;     // one enabled data bit while locked
    logic             load;     // a read is in progress this edge
    logic             capture;  // read of the lowest byte: take snapshot
    logic             inRange;  // read address falls inside the window
    logic [SEL_W-1:0] byteSel;  // byte index within the window
  } strobeT;

endpackage

// File: rtl/berTallyCtrl.sv
module berTallyCtrl
  import berTallyPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'hE3,
  parameter int NUM_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              syncOk,
  input  logic              clrCtl,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobeT            strb
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(NUM_BYTES);

  logic              clrQ;
  logic [ADDR_W-1:0] offset;
  logic              aboveBase;
  logic              belowTop;
  logic              hit;

  // Registered copy of the clear control level for edge detection.
  always_ff @(posedge clk) begin
    if (!rstN) clrQ <= 1'b0;
    else       clrQ <= clrCtl;
  end

  always_comb begin
    offset    = rdAddr - BASE_A;
    aboveBase = (rdAddr >= BASE_A);
    belowTop  = (offset < SPAN);
    hit       = aboveBase & belowTop;
  end

  always_comb begin
    strb.clear   = clrCtl & ~clrQ;
    strb.step    = bitEn & syncOk;
    strb.load    = rdEn;
    strb.inRange = hit;
    strb.capture = rdEn & hit & (offset == '0);
    strb.byteSel = offset[SEL_W-1:0];
  end

endmodule

// File: rtl/berTallyPath.sv
module berTallyPath
  import berTallyPkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovfFlag,
  output logic [BYTE_W-1:0] rdData
);

  localparam logic [CNT_W-1:0] TOP_VAL  = '1;
  localparam logic [CNT_W-1:0] NEAR_TOP = TOP_VAL - CNT_W'(1);

  logic              atTop;
  logic              advance;
  logic              reachTop;
  logic [CNT_W-1:0]  shadowQ;
  logic [BYTE_W-1:0] snapByte [NUM_BYTES];
  logic [BYTE_W-1:0] pickByte;

  always_comb begin
    atTop    = (cnt == TOP_VAL);
    advance  = strb.step & ~atTop;
    reachTop = advance & (cnt == NEAR_TOP);
  end

  // Saturating count; clear has priority over an increment.
  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (strb.clear)  cnt <= '0;
    else if (advance)     cnt <= cnt + CNT_W'(1);
  end

  // Sticky overflow flag, set on the edge the count lands on all-ones.
  always_ff @(posedge clk) begin
    if (!rstN)           ovfFlag <= 1'b0;
    else if (strb.clear) ovfFlag <= 1'b0;
    else if (reachTop)   ovfFlag <= 1'b1;
  end

  // Snapshot taken when the lowest byte is read.
  always_ff @(posedge clk) begin
    if (!rstN)             shadowQ <= '0;
    else if (strb.capture) shadowQ <= cnt;
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gSnapSlice
    assign snapByte[g] = shadowQ[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    pickByte = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (strb.byteSel == SEL_W'(i)) pickByte = snapByte[i];
    end
  end

  // Registered read data; holds between reads.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strb.load) begin
      if (strb.capture)      rdData <= cnt[BYTE_W-1:0];
      else if (strb.inRange) rdData <= pickByte;
      else                   rdData <= '0;
    end
  end

endmodule

// File: rtl/berBitTally.sv
module berBitTally
  import berTallyPkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'hE3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              syncOk,
  input  logic              clrCtl,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              ovfFlag
);

  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = CNT_W / BYTE_W;

  strobeT           strb;
  logic [CNT_W-1:0] cnt;

  berTallyCtrl #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .NUM_BYTES(NUM_BYTES)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .bitEn (bitEn),
    .syncOk(syncOk),
    .clrCtl(clrCtl),
    .rdEn  (rdEn),
    .rdAddr(rdAddr),
    .strb  (strb)
  );

  berTallyPath #(
    .CNT_W    (CNT_W),
    .BYTE_W   (BYTE_W),
    .NUM_BYTES(NUM_BYTES)
  ) path_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cnt    (cnt),
    .ovfFlag(ovfFlag),
    .rdData (rdData)
  );

endmodule

// File: rtl/berBitTallyChk.sv
module berBitTallyChk #(
  parameter int CNT_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'hE3,
  parameter int NUM_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              syncOk,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        rdData,
  input logic              ovfFlag,
  input logic [CNT_W-1:0]  cnt,
  input logic              strbClear,
  input logic              strbStep
);

  logic inWindow;
  assign inWindow = (int'(rdAddr) >= BASE_ADDR) &&
                    (int'(rdAddr) < BASE_ADDR + NUM_BYTES);

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    strbClear |=> (cnt == '0));

  assert_clear_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    strbClear |=> !ovfFlag);

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strbStep && !strbClear && !(&cnt)) |=> (cnt == $past(cnt) + CNT_W'(1)));

  assert_hold_unlocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!syncOk && !strbClear) |=> (cnt == $past(cnt)));

  assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((&cnt) && !strbClear) |=> (&cnt));

  assert_flag_at_top_R6: assert property (@(posedge clk) disable iff (!rstN)
    (&cnt) |-> ovfFlag);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strbClear) |=> ovfFlag);

  assert_outside_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !inWindow) |=> (rdData == 8'h00));

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

endmodule

bind berBitTally berBitTallyChk #(
  .CNT_W    (CNT_W),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR),
  .NUM_BYTES(NUM_BYTES)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .syncOk   (syncOk),
  .rdEn     (rdEn),
  .rdAddr   (rdAddr),
  .rdData   (rdData),
  .ovfFlag  (ovfFlag),
  .cnt      (cnt),
  .strbClear(strb.clear),
  .strbStep (strb.step)
);

// File: tb/berBitTally_tb_top.sv
`timescale 1ns/1ps
module berBitTally_tb_top;

  localparam longint MAX_B = 64'hFFFF_FFFF;
  localparam longint MAX_S = 64'h0000_FFFF;
  localparam int     BASE  = 'hE3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0, syncOk = 1'b0, clrCtl = 1'b0, rdEn = 1'b0;
  logic [7:0] rdAddr = 8'h00;
  logic [7:0] rdDataB, rdDataS;
  logic       ovfB, ovfS;

  int  nTests = 0;
  int  nFail  = 0;
  bit  done   = 0;

  // Bench model, computed from the requirements.
  longint   expB = 0, expS = 0;
  bit       ovfEB = 0, ovfES = 0;
  logic [31:0] snapB = '0;
  logic [15:0] snapS = '0;
  logic [7:0]  expRdB = '0, expRdS = '0;
  bit       prevClr = 0;

  always #4 clk = ~clk;

  berBitTally dut_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .syncOk(syncOk), .clrCtl(clrCtl),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdDataB), .ovfFlag(ovfB)
  );

  berBitTally #(.CNT_W(16)) dutSmall_i (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .syncOk(syncOk), .clrCtl(clrCtl),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdDataS), .ovfFlag(ovfS)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk({req, " rdData 32b"}, longint'(rdDataB), longint'(expRdB));
    chk({req, " rdData 16b"}, longint'(rdDataS), longint'(expRdS));
    chk({req, " ovf 32b"}, longint'(ovfB), longint'(ovfEB));
    chk({req, " ovf 16b"}, longint'(ovfS), longint'(ovfES));
  endtask

  // One cycle: drive at falling edge, update model, wait for next falling edge.
  task automatic cyc(input bit b, input bit s, input bit c, input bit r,
                     input logic [7:0] a);
    int off;
    bitEn = b; syncOk = s; clrCtl = c; rdEn = r; rdAddr = a;
    off = int'(a) - BASE;
    if (r) begin
      if (off == 0) begin
        expRdB = expB[7:0]; snapB = expB[31:0];
        expRdS = expS[7:0]; snapS = expS[15:0];
      end else begin
        expRdB = (off > 0 && off < 4) ? snapB[off*8 +: 8] : 8'h00;
        expRdS = (off == 1) ? snapS[15:8] : 8'h00;
      end
    end
    if (c && !prevClr) begin
      expB = 0; expS = 0; ovfEB = 0; ovfES = 0;
    end else if (b && s) begin
      if (expB < MAX_B) begin expB++; if (expB == MAX_B) ovfEB = 1; end
      if (expS < MAX_S) begin expS++; if (expS == MAX_S) ovfES = 1; end
    end
    prevClr = c;
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit b, input bit s);
    for (int i = 0; i < n; i++) cyc(b, s, prevClr, 1'b0, 8'h00);
  endtask

  task automatic readByte(input logic [7:0] a, input string req);
    cyc(1'b0, 1'b0, prevClr, 1'b1, a);
    checkAll(req);
  endtask

  task automatic readAll(input string req);
    for (int k = 0; k < 4; k++) readByte(8'(BASE + k), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    checkAll("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after reset");
    readAll("R1 R7 zero count");

    // R2: plain counting
    run(100, 1, 1);
    readAll("R2 R7 after 100");

    // R3: sweep of enable and lock combinations
    for (int m = 0; m < 4; m++) begin
      run(37 + m * 11, m[0], m[1]);
      readAll("R3 enable/lock sweep");
    end
    run(5, 1, 0);
    run(9, 1, 1);
    readAll("R3 resume after lock");

    // R4: clear beats increment; level and falling edge do nothing
    cyc(1, 1, 1, 0, 8'h00);
    readAll("R4 clear wins");
    run(50, 1, 1);
    readAll("R4 level high no clear");
    cyc(1, 1, 0, 0, 8'h00);
    run(10, 1, 1);
    readAll("R4 falling edge no clear");

    // R10: snapshot coherence
    run(700, 1, 1);
    readByte(8'hE3, "R10 capture");
    run(300, 1, 1);
    readByte(8'hE4, "R10 byte1 from snapshot");
    readByte(8'hE5, "R10 byte2 from snapshot");
    readByte(8'hE6, "R10 byte3 from snapshot");
    readAll("R10 fresh snapshot");

    // R5 R6: saturation of the 16-bit copy
    cyc(0, 0, 1, 0, 8'h00);
    cyc(0, 0, 0, 0, 8'h00);
    run(65534, 1, 1);
    readAll("R6 one below top");
    run(1, 1, 1);
    readAll("R6 reaches top");
    run(20, 1, 1);
    readAll("R5 R6 held at top");

    // R8: full address sweep, then hold check
    for (int a = 0; a < 256; a++) readByte(8'(a), "R8 R7 address sweep");
    readByte(8'hE5, "R8 last read");
    for (int i = 0; i < 5; i++) begin
      cyc(1, 1, 0, 0, 8'hE3);
      checkAll("R8 hold while idle");
    end

    // R9: clear drops the flag even with a concurrent increment
    cyc(1, 1, 1, 0, 8'h00);
    checkAll("R9 flag cleared");
    readAll("R9 R4 count cleared");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule